// File: doc/BRIEF.md
# While-lower loop predicate generator

This block turns a running loop index and a loop limit, both unsigned 64-bit scalars, into a loop-governing predicate for a vector of configurable length. The predicate carries one bit per vector byte. For the selected element size the lowest elements are switched on while the index plus the element number stays below the limit. The first element that fails the test, and every element above it, is switched off. The result is always an unbroken run of active elements that starts at the lowest one.

Alongside the predicate the block produces four condition flags, so that a loop can branch on the outcome: continue while the first element is active, and stop once nothing is active or the tail has been cut. Software issues one compare per loop iteration by pulsing a start strobe. The predicate and flags are captured in registers and appear one clock later.

Top module: `wlp_while_lower`

## Requirements
- R1: Element e (numbered from 0) is active exactly when index + e, compared unsigned, is below the limit; with index >= limit no element is active.
- R2: The active elements form a contiguous run starting at element 0; after the first inactive element every higher element is inactive.
- R3: The predicate has VL_BITS/8 bits. The element-size code selects 1, 2, 4 or 8 bytes per element for the codes 0, 1, 2 and 3. Element e maps to predicate bit e × (bytes per element), and every other bit of its group is zero.
- R4: The sum index + e never wraps: when it exceeds 2^64 − 1 the element is inactive.
- R5: flags_out[3] (negative) is set exactly when element 0 is active.
- R6: flags_out[2] (zero) is set exactly when no element is active.
- R7: flags_out[1] (carry) is set exactly when the highest element for the chosen size is inactive.
- R8: flags_out[0] (overflow) is always zero.
- R9: valid_out is high in the cycle after a cycle with start high and is low otherwise. pred_out and flags_out change only after a start and otherwise hold their values.
- R10: During and after reset, before any start, pred_out, flags_out and valid_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe for one compare |
| index_in | input | 64 | Running loop index, unsigned |
| limit_in | input | 64 | Loop limit, unsigned |
| esize_in | input | 2 | Element size code (0 byte, 1 half, 2 word, 3 double) |
| pred_out | output | VL_BITS/8 | Predicate, one bit per vector byte |
| flags_out | output | 4 | Flags {N, Z, C, V} |
| valid_out | output | 1 | Result issued by the previous start |

## Verification
The checker copies the index, limit and size code on every start, so its properties assume only that these inputs carry defined values in the cycle where start is high and that start stays low during reset. The bench changes inputs only on the falling edge. It pulses start for exactly one cycle, followed by idle cycles, so every result has a clean capture and a hold window. The index and limit sweeps cover both the region near zero and the region near 2^64 − 1, where the no-wrap rule and an empty predicate meet.

// File: rtl/wlp_pkg.sv
package wlp_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // True when idx + off stays below lim, computed one bit wider so a carry
  // out of 64 bits reads as "not below".
  function automatic logic below_limit(input logic [63:0] idx,
                                       input logic [63:0] lim,
                                       input logic [63:0] off);
    logic [64:0] sum;
    sum = {1'b0, idx} + {1'b0, off};
    return sum < {1'b0, lim};
  endfunction

  // True when a byte lane is the lowest byte of its element.
  function automatic logic lane_leads(input int unsigned lane,
                                      input logic [1:0] esz);
    int unsigned grp;
    grp = (32'd1 << esz) - 32'd1;
    return (lane & grp) == 0;
  endfunction

endpackage

// File: rtl/wlp_lane_array.sv
module wlp_lane_array #(
  parameter int unsigned PRED_BITS = 64
) (
  input  logic [63:0]          idx,
  input  logic [63:0]          lim,
  input  logic [1:0]           esz,
  output logic [PRED_BITS-1:0] pred_raw
);

  for (genvar g = 0; g < PRED_BITS; g++) begin : g_lane
    logic        lead;
    logic [63:0] elem;
    assign lead = wlp_pkg::lane_leads(g, esz);
    assign elem = 64'(g) >> esz;
    assign pred_raw[g] = lead && wlp_pkg::below_limit(idx, lim, elem);
  end

endmodule

// File: rtl/wlp_flag_unit.sv
module wlp_flag_unit #(
  parameter int unsigned PRED_BITS = 64
) (
  input  logic [PRED_BITS-1:0] pred,
  input  logic [1:0]           esz,
  output wlp_pkg::nzcv_t       flags
);

  localparam int unsigned LW = $clog2(PRED_BITS);

  logic [LW-1:0] last_lane;
  logic          first_on;
  logic          last_on;
  logic          any_on;

  // Lowest byte lane of the highest element for this size.
  assign last_lane = LW'(PRED_BITS - (32'd1 << esz));
  assign first_on  = pred[0];
  assign last_on   = pred[last_lane];
  assign any_on    = |pred;

  always_comb begin
    flags.n = first_on;
    flags.z = ~any_on;
    flags.c = ~last_on;
    flags.v = 1'b0;
  end

endmodule

// File: rtl/wlp_while_lower.sv
module wlp_while_lower #(
  parameter int unsigned VL_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [63:0]          index_in,
  input  logic [63:0]          limit_in,
  input  logic [1:0]           esize_in,
  output logic [VL_BITS/8-1:0] pred_out,
  output logic [3:0]           flags_out,
  output logic                 valid_out
);

  localparam int unsigned PRED_BITS = VL_BITS / 8;

  logic [PRED_BITS-1:0] pred_next;
  wlp_pkg::nzcv_t       flags_next;

  wlp_lane_array #(.PRED_BITS(PRED_BITS)) u_lanes (
    .idx      (index_in),
    .lim      (limit_in),
    .esz      (esize_in),
    .pred_raw (pred_next)
  );

  wlp_flag_unit #(.PRED_BITS(PRED_BITS)) u_flags (
    .pred  (pred_next),
    .esz   (esize_in),
    .flags (flags_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_out  <= '0;
      flags_out <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= start;
      if (start) begin
        pred_out  <= pred_next;
        flags_out <= flags_next;
      end
    end
  end

endmodule

// File: rtl/wlp_while_lower_chk.sv
module wlp_while_lower_chk #(
  parameter int unsigned PRED_BITS = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [63:0]          index_in,
  input logic [63:0]          limit_in,
  input logic [1:0]           esize_in,
  input logic [PRED_BITS-1:0] pred_out,
  input logic [3:0]           flags_out,
  input logic                 valid_out
);

  logic [63:0]          idx_q;
  logic [63:0]          lim_q;
  logic [1:0]           esz_q;
  logic [PRED_BITS-1:0] lead_mask;
  logic [PRED_BITS-1:0] elem_bits;
  logic                 is_prefix;
  logic                 stray_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      lim_q <= '0;
      esz_q <= '0;
    end else if (start) begin
      idx_q <= index_in;
      lim_q <= limit_in;
      esz_q <= esize_in;
    end
  end

  always_comb begin
    lead_mask = '0;
    elem_bits = '0;
    for (int b = 0; b < PRED_BITS; b++) begin
      if ((b % (1 << esz_q)) == 0) begin
        lead_mask[b] = 1'b1;
        elem_bits[b >> esz_q] = pred_out[b];
      end
    end
  end

  assign is_prefix  = (elem_bits & (elem_bits + 1'b1)) == '0;
  assign stray_bits = |(pred_out & ~lead_mask);

  AST_INDEX_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && (idx_q >= lim_q) |-> pred_out == '0);                     // R1
  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> is_prefix);                                              // R2
  AST_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> !stray_bits);                                            // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out && (&idx_q) |-> pred_out == '0);                             // R4
  AST_N_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> flags_out[3] == pred_out[0]);                            // R5
  AST_Z_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> flags_out[2] == (pred_out == '0));                       // R6
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> !flags_out[0]);                                          // R8
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid_out);                                                  // R9
  AST_VALID_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid_out);                                                // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(pred_out) && $stable(flags_out));                   // R9

endmodule

bind wlp_while_lower wlp_while_lower_chk #(.PRED_BITS(PRED_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .index_in  (index_in),
  .limit_in  (limit_in),
  .esize_in  (esize_in),
  .pred_out  (pred_out),
  .flags_out (flags_out),
  .valid_out (valid_out)
);

// File: tb/test_wlp_while_lower.sv
`timescale 1ns/1ps
module test_wlp_while_lower;

  localparam int unsigned VL = 128;
  localparam int unsigned PB = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   index_in = '0;
  logic [63:0]   limit_in = '0;
  logic [1:0]    esize_in = '0;
  logic [PB-1:0] pred_out;
  logic [3:0]    flags_out;
  logic          valid_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wlp_while_lower #(.VL_BITS(VL)) i_wlp_while_lower (
    .clk(clk), .rst_n(rst_n), .start(start), .index_in(index_in),
    .limit_in(limit_in), .esize_in(esize_in), .pred_out(pred_out),
    .flags_out(flags_out), .valid_out(valid_out)
  );

  // Number of active elements: the distance to the limit, capped at the
  // element count; zero when the index has reached the limit.
  function automatic int unsigned active_count(input logic [63:0] idx,
                                               input logic [63:0] lim,
                                               input logic [1:0] esz);
    int unsigned n;
    logic [63:0] gap;
    n = PB >> esz;
    if (lim <= idx) return 0;
    gap = lim - idx;
    return (gap >= 64'(n)) ? n : int'(gap);
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] idx, input logic [63:0] lim,
                         input logic [1:0] esz);
    int unsigned cnt;
    int unsigned n;
    logic [PB-1:0] ep;
    logic [3:0] ef;
    n   = PB >> esz;
    cnt = active_count(idx, lim, esz);
    ep  = '0;
    for (int e = 0; e < PB; e++) if (e < cnt) ep[e * (1 << esz)] = 1'b1;
    ef = {cnt > 0, cnt == 0, cnt < n, 1'b0};
    @(negedge clk);
    index_in = idx; limit_in = lim; esize_in = esz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 valid after start", 64'(valid_out), 64'd1);
    check("R1 R2 R3 R4 predicate", 64'(pred_out), 64'(ep));
    check("R5 negative flag", 64'(flags_out[3]), 64'(ef[3]));
    check("R6 zero flag", 64'(flags_out[2]), 64'(ef[2]));
    check("R7 carry flag", 64'(flags_out[1]), 64'(ef[1]));
    check("R8 overflow flag", 64'(flags_out[0]), 64'd0);
    // New inputs without a start must leave the result alone.
    index_in = ~idx; limit_in = ~lim; esize_in = ~esz;
    @(negedge clk);
    check("R9 valid drops", 64'(valid_out), 64'd0);
    check("R9 hold predicate", 64'(pred_out), 64'(ep));
    check("R9 hold flags", 64'(flags_out), 64'(ef));
  endtask

  initial begin
    #1;
    check("R10 reset predicate", 64'(pred_out), 64'd0);
    check("R10 reset flags", 64'(flags_out), 64'd0);
    check("R10 reset valid", 64'(valid_out), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", 64'({pred_out, flags_out, valid_out}), 64'd0);
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 20; i++)
        for (int l = 0; l < 20; l++)
          run_one(64'(i), 64'(l), 2'(s));
      // Near the top of the range: R4 no wrap
      for (int i = 0; i < 20; i++) begin
        run_one(64'hFFFF_FFFF_FFFF_FFF0 + 64'(i), '1, 2'(s));
        run_one(64'hFFFF_FFFF_FFFF_FFF0 + 64'(i), 64'hFFFF_FFFF_FFFF_FFF8, 2'(s));
      end
      run_one('1, '1, 2'(s));
      run_one(64'd5, 64'h8000_0000_0000_0000, 2'(s));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule